// File: doc/BRIEF.md
# Response Buffer Serial/Parallel Readout

This unit keeps a 256-bit device-signature response in a register and streams it out in one of two formats. Bits are loaded one at a time through an indexed write port while the unit is idle. Once the producer signals that the buffer is full, a clock-enable pulse starts a transfer. Each later pulse then emits one item on an 8-bit output port. An output-valid flag and an item index come out with each item.

A mode input picks the format when a transfer starts. A value of 0 gives thirty-two 8-bit words. A value of 1 gives 256 single bits on bit 0 of the port. The serial readout rotates the register in a full circle, so the stored contents are intact afterwards and a parallel readout of the same response can follow. While the buffer-full input stays high, transfers repeat back to back.

Top module: `resp_stream_unit`

## Requirements
- R1: After reset, `p_out`, `idx_out` and `out_valid` are all zero.
- R2: A write (`wr_en` high at a clock edge) while no transfer is active stores `wr_bit` at position `wr_idx`. Writes during a transfer are ignored and leave the stored response unchanged.
- R3: A transfer starts only at a `ce` pulse while idle with `buf_full` high. That start pulse emits no item and leaves `out_valid` low. Without `buf_full`, `ce` pulses start nothing.
- R4: During a transfer, each `ce` pulse emits exactly one item. Between pulses, `p_out`, `idx_out` and `out_valid` hold their values.
- R5: In parallel mode (`mode_sel` = 0), exactly 32 words are emitted. Word k carries stored bit 8k+n on `p_out[n]`, and `idx_out` equals k, zero-extended.
- R6: In serial mode (`mode_sel` = 1), exactly 256 items are emitted in ascending order. Item i carries stored bit i on `p_out[0]`, `p_out[7:1]` is zero, and `idx_out` equals i.
- R7: A serial transfer leaves the stored response unchanged, so a following parallel transfer returns the same data without reloading.
- R8: The mode is sampled at the start pulse. A change of `mode_sel` during a transfer does not affect that transfer.
- R9: `out_valid` rises with each emitted item. It falls at the first `ce` pulse after the last item, when the unit is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Clock enable; one item per pulse during a transfer |
| wr_en | input | 1 | Bit write strobe |
| wr_idx | input | 8 | Bit position to write |
| wr_bit | input | 1 | Bit value to write |
| buf_full | input | 1 | Response complete; permits a transfer to start |
| mode_sel | input | 1 | 0 = 8-bit words, 1 = single bits |
| p_out | output | 8 | Output data; serial items use bit 0 |
| idx_out | output | 8 | Word index (parallel) or bit index (serial) of the current item |
| out_valid | output | 1 | Current item is valid |

## Verification
The readout is driven with several loaded patterns in both modes. The patterns are irregular, so a swapped bit order inside a word, an off-by-one word base, or a rotation in the wrong direction each give a mismatch that can be located. A serial run followed by a parallel run with no reload separates a true circular rotation from a destructive shift. A run that writes a bit and flips the mode in mid-transfer shows whether either leaks into the stream or into the stored data. Pulses with the buffer not full, and gaps between enable pulses, check the start condition and the hold behaviour.

// File: rtl/resp_stream_pkg.sv
package resp_stream_pkg;
  typedef enum logic {MODE_PAR = 1'b0, MODE_SER = 1'b1} rs_mode_e;

  // Number of items in one transfer for a given mode.
  function automatic int unsigned items_for(rs_mode_e m, int unsigned width, int unsigned lane);
    return (m == MODE_SER) ? width : width / lane;
  endfunction
endpackage

// File: rtl/resp_stream_store.sv
module resp_stream_store #(
  parameter int WIDTH = 256,
  parameter int IW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic             wr_bit,
  input  logic             rot,
  output logic [WIDTH-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
    end else if (rot) begin
      // right rotation: bit 0 leaves, comes back at the top
      data <= {data[0], data[WIDTH-1:1]};
    end else if (wr_en && wr_ok) begin
      data[wr_idx] <= wr_bit;
    end
  end
endmodule

// File: rtl/resp_stream_seq.sv
module resp_stream_seq
  import resp_stream_pkg::*;
#(
  parameter int WIDTH = 256,
  parameter int LANE  = 8,
  parameter int IW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          buf_full,
  input  rs_mode_e      mode_sel,
  output logic          busy,
  output logic          start_evt,
  output logic          emit_evt,
  output logic          last_evt,
  output rs_mode_e      mode_q,
  output logic [IW-1:0] cnt
);
  logic [IW-1:0] last_idx;

  assign last_idx  = IW'(items_for(mode_q, WIDTH, LANE) - 1);
  assign start_evt = ce && !busy && buf_full;
  assign emit_evt  = ce && busy;
  assign last_evt  = emit_evt && (cnt == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_q <= MODE_PAR;
      cnt    <= '0;
    end else if (start_evt) begin
      busy   <= 1'b1;
      mode_q <= mode_sel;
      cnt    <= '0;
    end else if (emit_evt) begin
      cnt <= cnt + 1'b1;
      if (last_evt) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/resp_stream_fmt.sv
module resp_stream_fmt
  import resp_stream_pkg::*;
#(
  parameter int WIDTH = 256,
  parameter int LANE  = 8,
  parameter int IW    = 8,
  parameter int WIW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             emit,
  input  rs_mode_e         mode,
  input  logic [IW-1:0]    cnt,
  input  logic [WIDTH-1:0] data,
  output logic [LANE-1:0]  p_out,
  output logic [IW-1:0]    idx_out,
  output logic             out_valid
);
  function automatic logic [LANE-1:0] pick_word(input logic [WIDTH-1:0] d,
                                                input logic [WIW-1:0] k);
    return d[k*LANE +: LANE];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_out     <= '0;
      idx_out   <= '0;
      out_valid <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      if (mode == MODE_SER) begin
        p_out   <= {{(LANE-1){1'b0}}, data[0]};
        idx_out <= cnt;
      end else begin
        p_out   <= pick_word(data, cnt[WIW-1:0]);
        idx_out <= IW'(cnt[WIW-1:0]);
      end
    end else if (ce) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/resp_stream_unit.sv
module resp_stream_unit
  import resp_stream_pkg::*;
#(
  parameter int WIDTH = 256,
  parameter int LANE  = 8,
  localparam int IW   = $clog2(WIDTH),
  localparam int WIW  = $clog2(WIDTH / LANE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic            wr_bit,
  input  logic            buf_full,
  input  logic            mode_sel,
  output logic [LANE-1:0] p_out,
  output logic [IW-1:0]   idx_out,
  output logic            out_valid
);
  logic             busy;
  logic             start_evt;
  logic             emit_evt;
  logic             last_evt;
  rs_mode_e         mode_q;
  logic [IW-1:0]    item_cnt;
  logic [WIDTH-1:0] resp_data;
  logic             rot_evt;

  assign rot_evt = emit_evt && (mode_q == MODE_SER);

  resp_stream_seq #(.WIDTH(WIDTH), .LANE(LANE), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ce(ce), .buf_full(buf_full),
    .mode_sel(rs_mode_e'(mode_sel)), .busy(busy), .start_evt(start_evt),
    .emit_evt(emit_evt), .last_evt(last_evt), .mode_q(mode_q), .cnt(item_cnt)
  );

  resp_stream_store #(.WIDTH(WIDTH), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(!busy), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_bit(wr_bit), .rot(rot_evt), .data(resp_data)
  );

  resp_stream_fmt #(.WIDTH(WIDTH), .LANE(LANE), .IW(IW), .WIW(WIW)) u_fmt (
    .clk(clk), .rst_n(rst_n), .ce(ce), .emit(emit_evt), .mode(mode_q),
    .cnt(item_cnt), .data(resp_data), .p_out(p_out), .idx_out(idx_out),
    .out_valid(out_valid)
  );
endmodule

// File: rtl/resp_stream_chk.sv
module resp_stream_chk #(
  parameter int WIDTH = 256,
  parameter int LANE  = 8,
  parameter int IW    = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce,
  input logic            buf_full,
  input logic            busy,
  input logic            start_evt,
  input logic            emit_evt,
  input logic            last_evt,
  input logic            mode_q,
  input logic [LANE-1:0] p_out,
  input logic [IW-1:0]   idx_out,
  input logic            out_valid
);
  assert_start_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> buf_full);

  assert_start_no_item_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !out_valid);

  assert_valid_after_emit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    emit_evt |=> out_valid);

  assert_hold_without_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(p_out) && $stable(idx_out) && $stable(out_valid)));

  assert_word_index_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !mode_q) |-> (idx_out < IW'(WIDTH / LANE)));

  assert_serial_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q) |-> (p_out[LANE-1:1] == '0));

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

  assert_last_goes_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> !busy);

  assert_idle_ce_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !busy) |=> !out_valid);
endmodule

bind resp_stream_unit resp_stream_chk #(.WIDTH(WIDTH), .LANE(LANE), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .buf_full(buf_full), .busy(busy),
  .start_evt(start_evt), .emit_evt(emit_evt), .last_evt(last_evt),
  .mode_q(mode_q), .p_out(p_out), .idx_out(idx_out), .out_valid(out_valid)
);

// File: tb/sim_resp_stream_unit.sv
module sim_resp_stream_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_idx = '0;
  logic       wr_bit = 1'b0;
  logic       buf_full = 1'b0;
  logic       mode_sel = 1'b0;
  logic [7:0] p_out;
  logic [7:0] idx_out;
  logic       out_valid;

  int checks = 0;
  int fails = 0;
  logic shadow [256];

  // each row: pattern seed, mode (0 = words, 1 = bits)
  localparam logic [16:0] VEC [4] = '{
    {16'h0025, 1'b1}, {16'h0025, 1'b0}, {16'h00B3, 1'b0}, {16'h0011, 1'b1}
  };

  always #10 clk = ~clk;

  resp_stream_unit u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_bit(wr_bit), .buf_full(buf_full), .mode_sel(mode_sel),
    .p_out(p_out), .idx_out(idx_out), .out_valid(out_valid)
  );

  function automatic logic pat(input int i, input int seed);
    return logic'((((i * seed) + (i >> 2)) >> 3) & 1) ^ (i % 3 == 0);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after one enable edge
  task automatic step(input logic c);
    ce = c;
    @(negedge clk);
    ce = 1'b0;
  endtask

  task automatic write_bit(input int i, input logic b);
    wr_en = 1'b1; wr_idx = 8'(i); wr_bit = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int seed);
    for (int i = 0; i < 256; i++) begin
      shadow[i] = pat(i, seed);
      write_bit(i, shadow[i]);
    end
  endtask

  // inject: write a flipped bit and toggle the mode mid-transfer
  task automatic run(input logic mode, input logic inject);
    int n;
    logic [7:0] e;
    n = mode ? 256 : 32;
    mode_sel = mode;
    buf_full = 1'b1;
    step(1'b1);
    buf_full = 1'b0;
    check(out_valid == 1'b0, "R3 start pulse emits nothing", int'(out_valid), 0);
    for (int k = 0; k < n; k++) begin
      if (inject && k == 2) begin
        write_bit(40, ~shadow[40]);   // R2: must be ignored
        mode_sel = ~mode;             // R8: must be ignored
      end
      step(1'b1);
      if (mode) begin
        e = {7'b0, shadow[k]};
        check(p_out == e && idx_out == 8'(k) && out_valid,
              "R6 serial item", int'({out_valid, idx_out, p_out}), int'({1'b1, 8'(k), e}));
      end else begin
        for (int b = 0; b < 8; b++) e[b] = shadow[8*k + b];
        check(p_out == e && idx_out == 8'(k) && out_valid,
              "R5 parallel word", int'({out_valid, idx_out, p_out}), int'({1'b1, 8'(k), e}));
      end
      if (k == 3) begin
        @(negedge clk); @(negedge clk);
        check(p_out == e && idx_out == 8'(k) && out_valid,
              "R4 hold without ce", int'({out_valid, idx_out, p_out}), int'({1'b1, 8'(k), e}));
      end
    end
    mode_sel = mode;
    step(1'b1);
    check(out_valid == 1'b0, "R9 valid low after last item", int'(out_valid), 0);
    check(idx_out == 8'(n - 1), "R9 no extra item", int'(idx_out), n - 1);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check(p_out == 8'h00 && idx_out == 8'h00 && out_valid == 1'b0, "R1 reset outputs",
          int'({out_valid, idx_out, p_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: enable pulses with buffer not full start nothing
    for (int i = 0; i < 3; i++) step(1'b1);
    check(out_valid == 1'b0 && idx_out == 8'h00, "R3 no start without buf_full",
          int'({out_valid, idx_out}), 0);

    // table-driven transfers; loads also exercise R2 writes
    for (int v = 0; v < 4; v++) begin
      load(int'(VEC[v][16:1]));
      run(VEC[v][0], 1'b0);
    end

    // R7: serial then parallel on the same stored data, no reload
    load(16'h0059);
    run(1'b1, 1'b0);
    run(1'b0, 1'b0);   // R7 parallel after serial

    // R2 / R8: write and mode change mid-transfer are ignored
    load(16'h0047);
    run(1'b1, 1'b1);
    run(1'b0, 1'b1);
    run(1'b0, 1'b0);   // R2 stored data still matches

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule